// File: doc/BRIEF.md
# Shift-Feedback State Sequence Generator

This block is a free-running three-stage synchronous sequencer. The stages are q1, q2 and q3, and q1 is the most significant bit of the exposed state code. On every rising clock edge, q1 takes the NAND of all three stages. q2 takes the old q1, and q3 takes the old q2. No data input steers the transitions. The machine settles into a four-state ring: 101, 110, 111, 011, then back to 101. States 000, 001, 010 and 100 are entry states that lead into the ring within at most two steps.

The block exposes several outputs that a neighbour can observe:
- the current state code;
- a one-hot decode with one bit for each of the eight codes;
- a flag that is high while the state is on the ring, and its complement, which marks the entry states;
- a free-running counter of clock cycles since reset.

A synchronous active-high reset puts the state at 000. A synchronous preset port can place the machine in any code. This lets every node of the transition graph be reached, including 001 and 010, which nothing else can reach.

Top module: `shift_seq_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 000 and `cycles` becomes 0. Reset takes priority over preset.
- R2: With `rst` and `preset_en` low, the next q1 (state bit 2) is the NAND of the current q1, q2 and q3.
- R3: With `rst` and `preset_en` low, the next q2 (bit 1) equals the current q1, and the next q3 (bit 0) equals the current q2.
- R4: After reset, the machine visits 100, 110, 111 and 011, in that order.
- R5: The ring is closed: 011 goes to 101, 101 goes to 110, 110 goes to 111, and 111 goes to 011.
- R6: The entry states lead into the ring: 001 goes to 100, 010 goes to 101, 000 goes to 100, and 100 goes to 110.
- R7: `state_hot` has exactly one bit set, at the index equal to the state value {q1,q2,q3}.
- R8: `in_loop` is high exactly for states 011, 101, 110 and 111. `transient` is high exactly for the other four states.
- R9: When `preset_en` is high and `rst` is low at an edge, the state becomes `preset_val`.
- R10: `cycles` rises by one at every edge where `rst` is low, and it wraps to 0 after reaching its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| preset_en | input | 1 | Load `preset_val` into the state at the next edge |
| preset_val | input | 3 | State code to load, {q1,q2,q3} |
| state | output | 3 | Current state {q1,q2,q3} |
| state_hot | output | 8 | One-hot decode of `state` |
| in_loop | output | 1 | High while the state is on the four-state ring |
| transient | output | 1 | High while the state is an entry state |
| cycles | output | CNT_W | Cycles since reset, wrapping |

## Verification
Every one of the eight codes is preset and then stepped once. Each step is compared with a hand-derived successor table, so that a wrong feedback term or a wrong shift tap leads to the wrong node. The preset phase also checks the decode and the ring flags for every code. This separates the four ring codes from the four entry codes and catches any swapped decode index. A free run from reset confirms the entry path and that the ring closes on itself. The counter is checked both mid-run and across its wrap point, and reset is checked against a preset applied in the same cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int STATE_W    = 3;
    localparam int NUM_STATES = 1 << STATE_W;

    typedef struct packed {
        logic q1;
        logic q2;
        logic q3;
    } seq_state_t;

    localparam seq_state_t START_STATE = '{q1: 1'b0, q2: 1'b0, q3: 1'b0};

    // Feedback: NAND of all stages into the head, plain shift behind it.
    function automatic seq_state_t step(input seq_state_t s);
        seq_state_t n;
        n.q1 = ~(s.q1 & s.q2 & s.q3);
        n.q2 = s.q1;
        n.q3 = s.q2;
        return n;
    endfunction

    // Ring membership: 011, 101, 110, 111 (two or more stages set).
    function automatic logic on_ring(input seq_state_t s);
        return (s.q1 & s.q2) | (s.q1 & s.q3) | (s.q2 & s.q3);
    endfunction

    function automatic logic [STATE_W-1:0] to_bits(input seq_state_t s);
        return {s.q1, s.q2, s.q3};
    endfunction

endpackage

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                preset_en,
    input  seq_state_t          preset_val,
    output seq_state_t          cur
);

    seq_state_t nxt;

    always_comb begin
        if (preset_en) nxt = preset_val;
        else           nxt = step(cur);
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= START_STATE;
        else     cur <= nxt;
    end

    // R1: reset lands on the start code
    a_r1_reset_start: assert property (@(posedge clk)
        rst |=> (cur == START_STATE));

    // R2: head stage is the NAND of all stages
    a_r2_nand_head: assert property (@(posedge clk) disable iff (rst)
        (!rst && !preset_en) |=> (cur.q1 == ~($past(cur.q1) & $past(cur.q2) & $past(cur.q3))));

    // R3: tail stages shift
    a_r3_shift_tail: assert property (@(posedge clk) disable iff (rst)
        (!rst && !preset_en) |=> (cur.q2 == $past(cur.q1) && cur.q3 == $past(cur.q2)));

    // R9: preset loads the given code
    a_r9_preset_load: assert property (@(posedge clk) disable iff (rst)
        (!rst && preset_en) |=> (cur == $past(preset_val)));

endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  seq_state_t              cur,
    output logic [NUM_STATES-1:0]   hot,
    output logic                    ring,
    output logic                    entry
);

    logic [STATE_W-1:0] code;
    assign code = to_bits(cur);

    for (genvar g = 0; g < NUM_STATES; g++) begin : g_hot
        assign hot[g] = (code == STATE_W'(g));
    end

    assign ring  = on_ring(cur);
    assign entry = ~ring;

    // R7: exactly one decode bit set
    a_r7_one_hot: assert property (@(posedge clk) disable iff (rst)
        $countones(hot) == 1);

    // R8: ring flag agrees with the decoded ring codes
    a_r8_ring_codes: assert property (@(posedge clk) disable iff (rst)
        ring == (hot[3] | hot[5] | hot[6] | hot[7]));

endmodule

// File: rtl/seq_cycle_ctr.sv
module seq_cycle_ctr #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + ONE;
    end

    // R10: advances by one (modulo width) on every non-reset edge
    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (count == $past(count) + ONE));

endmodule

// File: rtl/shift_seq_gen.sv
module shift_seq_gen
    import seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  preset_en,
    input  logic [2:0]            preset_val,
    output logic [2:0]            state,
    output logic [7:0]            state_hot,
    output logic                  in_loop,
    output logic                  transient,
    output logic [CNT_W-1:0]      cycles
);

    seq_state_t cur;

    seq_core u_core (
        .clk        (clk),
        .rst        (rst),
        .preset_en  (preset_en),
        .preset_val (seq_state_t'(preset_val)),
        .cur        (cur)
    );

    seq_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur),
        .hot   (state_hot),
        .ring  (in_loop),
        .entry (transient)
    );

    seq_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .count (cycles)
    );

    assign state = to_bits(cur);

    // R5: once on the ring, free running stays on the ring
    a_r5_ring_closed: assert property (@(posedge clk) disable iff (rst)
        (in_loop && !preset_en) |=> in_loop);

    // R6: an entry state reaches the ring within two free-running steps
    a_r6_entry_leads_in: assert property (@(posedge clk) disable iff (rst)
        (transient && !preset_en && (state != 3'b000)) |=> (in_loop || state == 3'b110 || state == 3'b100));

endmodule

// File: tb/shift_seq_gen_tb.sv
module shift_seq_gen_tb;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          preset_en = 1'b0;
    logic [2:0]    preset_val = 3'b000;
    logic [2:0]    state;
    logic [7:0]    state_hot;
    logic          in_loop;
    logic          transient;
    logic [CW-1:0] cycles;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    shift_seq_gen #(.CNT_W(CW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .preset_en  (preset_en),
        .preset_val (preset_val),
        .state      (state),
        .state_hot  (state_hot),
        .in_loop    (in_loop),
        .transient  (transient),
        .cycles     (cycles)
    );

    // {code, successor, on_ring}
    localparam logic [6:0] VEC [8] = '{
        7'b000_100_0, 7'b001_100_0, 7'b010_101_0, 7'b011_101_1,
        7'b100_110_0, 7'b101_110_1, 7'b110_111_1, 7'b111_011_1
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        logic [2:0] seq_exp [6];
        seq_exp = '{3'b100, 3'b110, 3'b111, 3'b011, 3'b101, 3'b110};

        // R1 reset state
        rst = 1'b1;
        tick(); tick();
        check("R1 state", state, 3'b000);
        check("R1 cycles", cycles, 0);
        check("R7 hot at reset", state_hot, 8'h01);
        check("R8 transient at reset", transient, 1);

        // R4/R5 free run from the start code; R10 counter alongside
        rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tick();
            check("R4 R5 sequence", state, seq_exp[k]);
        end
        check("R10 cycles after 6", cycles, 6);
        for (int k = 0; k < 9; k++) tick();
        check("R10 cycles before wrap", cycles, 15);
        tick();
        check("R10 cycles wrap", cycles, 0);

        // R2 R3 R6 R7 R8 R9 full graph walk from every code
        for (int i = 0; i < 8; i++) begin
            logic [2:0] c;
            logic [2:0] n;
            logic       r;
            {c, n, r} = VEC[i];
            preset_en  = 1'b1;
            preset_val = c;
            tick();
            check("R9 preset", state, c);
            check("R7 decode", state_hot, 1 << c);
            check("R8 in_loop", in_loop, r);
            check("R8 transient", transient, !r);
            preset_en = 1'b0;
            tick();
            check("R2 R3 R5 R6 successor", state, n);
        end

        // R1 reset beats preset
        preset_en  = 1'b1;
        preset_val = 3'b111;
        rst        = 1'b1;
        tick();
        check("R1 reset over preset", state, 3'b000);
        check("R1 cycles cleared", cycles, 0);
        rst       = 1'b0;
        preset_en = 1'b0;
        tick();
        check("R4 first step", state, 3'b100);
        check("R10 count one", cycles, 1);

        finish_run();
    end

endmodule